// File: doc/BRIEF.md
# Message-signalled interrupt vector dispatcher

The dispatcher sits between the interrupt sources of a device function and its bus master port. A source raises a one-cycle request naming a vector. The block checks the vector against the number of vectors that software allocated, and drops the request when the function is disabled. It then either turns the request into a memory-write message or parks it in a pending bit. The message carries the programmed target address, a 32-bit payload built from the programmed data word and the vector number, and the function's requester ID. It leaves on a valid/ready handshake, and only one message is outstanding at a time.

When per-vector masking is supported, a request for a masked vector sets that vector's pending bit and sends nothing. A request that arrives while the output is busy or a drain is running also becomes a pending bit. A configuration-write pulse trims pending bits that fall outside the allocated range. The block then drains the unmasked pending vectors, lowest number first, and clears each bit as its message is issued. The register decode lives elsewhere: this block only sees the decoded configuration values and the write pulse.

Top module: `msi_vec_dispatch`

## Requirements
- R1: The allocated count is 2^min(cfg_log_vec, NVEC_LOG). A request with req_vec at or above that count sends nothing and sets no pending bit. Whatever the enable state, req_bad is high for exactly the one cycle after that request.
- R2: While cfg_enable is low, a legal request sends no message and changes no pending bit.
- R3: If the output slot is idle and no drain has eligible work, an unmasked legal request makes msg_valid high after the next clock edge.
- R4: msg_data[31:16] is zero. When the count is 1, msg_data[15:0] equals cfg_data. Otherwise its low log2(count) bits hold the vector number and the bits above come from cfg_data.
- R5: When cfg_addr64 is 1, msg_addr is cfg_addr with bits [1:0] forced to zero. When cfg_addr64 is 0, bits [63:32] are also zero. msg_rid equals func_rid.
- R6: With cfg_mask_cap high, a legal enabled request for a vector whose cfg_mask bit (bit position = vector number) is 1 sets pend_bits at that position and sends no message.
- R7: A cfg_wr_pulse while cfg_enable and cfg_mask_cap are high clears every pending bit at or above the allocated count.
- R8: After that pulse, the pending vectors whose mask bit is 0 are sent one by one in ascending vector order, and each one's pending bit is cleared. Masked pending bits stay set.
- R9: While msg_valid is high and msg_ready is low, msg_valid, msg_addr and msg_data hold. With cfg_mask_cap high, a request that arrives then is kept as a pending bit and sent in ascending order once the output frees.
- R10: With cfg_mask_cap low, pend_bits stays zero and cfg_mask has no effect. A request that arrives while a message is outstanding is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Message delivery enabled |
| cfg_mask_cap | input | 1 | Per-vector masking supported |
| cfg_addr64 | input | 1 | 64-bit target address mode |
| cfg_addr | input | ADDR_W | Programmed target address |
| cfg_data | input | 16 | Programmed message data word |
| cfg_log_vec | input | 3 | log2 of the allocated vector count (clamped to NVEC_LOG) |
| cfg_mask | input | 2^NVEC_LOG | Per-vector mask, bit n masks vector n |
| cfg_wr_pulse | input | 1 | One-cycle strobe marking a configuration write |
| func_rid | input | RID_W | Requester ID of the function |
| req_valid | input | 1 | Interrupt request strobe |
| req_vec | input | NVEC_LOG | Requested vector number |
| req_bad | output | 1 | Pulse: the previous request was out of range |
| pend_bits | output | 2^NVEC_LOG | Pending vector bits |
| msg_valid | output | 1 | Message write request valid |
| msg_ready | input | 1 | Bus accepts the message |
| msg_addr | output | ADDR_W | Message target address |
| msg_data | output | 32 | Message payload |
| msg_rid | output | RID_W | Message requester ID |

## Verification
The directed cases cover the clamp of an oversize vector-count field, the out-of-range vector, and the single-vector case in which no data bits are replaced. A design that compares against the raw field, or that always merges the vector into the data, gives a wrong flag or wrong data there. The drain tests first leave some vectors masked and later release all of them. If the order is wrong, or if a bit is cleared while still masked, the captured message sequence comes out wrong. A stalled output with extra requests arriving catches designs that lose queued vectors or let the held message change. The trim test with a shrunk count catches pending bits that survive above the range. A random sweep without masking checks the payload merge and the address truncation over many field values.

// File: rtl/msi_disp_pkg.sv
package msi_disp_pkg;
   localparam int LOG_FLD_W  = 3;
   localparam int CFG_DATA_W = 16;
   localparam int PAYLOAD_W  = 32;

   // limit the programmed vector-count exponent to what the block was built for
   function automatic logic [LOG_FLD_W-1:0] clamp_log(input logic [LOG_FLD_W-1:0] fld,
                                                      input int lim);
      if (int'(fld) > lim) return LOG_FLD_W'(lim);
      return fld;
   endfunction
endpackage

// File: rtl/msi_vec_lim.sv
module msi_vec_lim
   import msi_disp_pkg::*;
#(
   parameter int NVEC_LOG = 5,
   localparam int NVEC = 1 << NVEC_LOG
) (
   input  logic [LOG_FLD_W-1:0] cfg_log_vec,
   input  logic [NVEC_LOG-1:0]  vec,
   output logic [LOG_FLD_W-1:0] eff_log,
   output logic [NVEC-1:0]      in_range,
   output logic [NVEC_LOG-1:0]  low_bits,
   output logic                 vec_ok
);
   assign eff_log = clamp_log(cfg_log_vec, NVEC_LOG);

   // one bit per vector slot: set when that slot lies below the allocated count
   for (genvar g = 0; g < NVEC; g++) begin : g_rng
      assign in_range[g] = ((NVEC_LOG'(g) >> eff_log) == '0);
   end

   // data bits that carry the vector number
   for (genvar b = 0; b < NVEC_LOG; b++) begin : g_low
      assign low_bits[b] = (LOG_FLD_W'(b) < eff_log);
   end

   assign vec_ok = in_range[vec];
endmodule

// File: rtl/msi_pend_arb.sv
module msi_pend_arb #(
   parameter int NVEC_LOG = 5,
   localparam int NVEC = 1 << NVEC_LOG
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap_en,
   input  logic                trim_en,
   input  logic [NVEC-1:0]     in_range,
   input  logic [NVEC-1:0]     blocked,
   input  logic [NVEC-1:0]     set_bits,
   input  logic [NVEC-1:0]     clr_bits,
   output logic [NVEC-1:0]     pnd,
   output logic                elig_any,
   output logic [NVEC-1:0]     pick_bits,
   output logic [NVEC_LOG-1:0] pick_idx
);
   logic [NVEC-1:0] pnd_q;
   logic [NVEC-1:0] elig;
   logic [NVEC-1:0] keep;
   logic [NVEC:0]   seen;

   assign elig     = pnd_q & ~blocked & in_range;
   assign elig_any = |elig;
   assign keep     = trim_en ? in_range : '1;

   // lowest eligible vector wins
   assign seen[0] = 1'b0;
   for (genvar i = 0; i < NVEC; i++) begin : g_pri
      assign pick_bits[i] = elig[i] & ~seen[i];
      assign seen[i+1]    = seen[i] | elig[i];
   end

   always_comb begin
      pick_idx = '0;
      for (int i = 0; i < NVEC; i++) begin
         if (pick_bits[i]) pick_idx = pick_idx | NVEC_LOG'(i);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       pnd_q <= '0;
      else if (!cap_en) pnd_q <= '0;
      else              pnd_q <= ((pnd_q & keep) & ~clr_bits) | set_bits;
   end

   assign pnd = pnd_q;
endmodule

// File: rtl/msi_msg_fmt.sv
module msi_msg_fmt
   import msi_disp_pkg::*;
#(
   parameter int ADDR_W   = 64,
   parameter int NVEC_LOG = 5
) (
   input  logic [ADDR_W-1:0]     cfg_addr,
   input  logic                  cfg_addr64,
   input  logic [CFG_DATA_W-1:0] cfg_data,
   input  logic [NVEC_LOG-1:0]   low_bits,
   input  logic [NVEC_LOG-1:0]   vec,
   output logic [ADDR_W-1:0]     addr,
   output logic [PAYLOAD_W-1:0]  data
);
   logic [CFG_DATA_W-1:0] lm;
   logic [CFG_DATA_W-1:0] vv;

   assign lm   = CFG_DATA_W'(low_bits);
   assign vv   = CFG_DATA_W'(vec) & lm;
   assign data = PAYLOAD_W'((cfg_data & ~lm) | vv);

   // target is dword aligned
   assign addr[1:0]  = 2'b00;
   if (ADDR_W > 32) begin : g_wide
      assign addr[31:2]       = cfg_addr[31:2];
      assign addr[ADDR_W-1:32] = cfg_addr64 ? cfg_addr[ADDR_W-1:32] : '0;
   end else begin : g_narrow
      assign addr[ADDR_W-1:2] = cfg_addr[ADDR_W-1:2];
   end
endmodule

// File: rtl/msi_vec_dispatch.sv
module msi_vec_dispatch
   import msi_disp_pkg::*;
#(
   parameter int NVEC_LOG = 5,
   parameter int ADDR_W   = 64,
   parameter int RID_W    = 16,
   localparam int NVEC = 1 << NVEC_LOG
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_enable,
   input  logic                  cfg_mask_cap,
   input  logic                  cfg_addr64,
   input  logic [ADDR_W-1:0]     cfg_addr,
   input  logic [CFG_DATA_W-1:0] cfg_data,
   input  logic [LOG_FLD_W-1:0]  cfg_log_vec,
   input  logic [NVEC-1:0]       cfg_mask,
   input  logic                  cfg_wr_pulse,
   input  logic [RID_W-1:0]      func_rid,
   input  logic                  req_valid,
   input  logic [NVEC_LOG-1:0]   req_vec,
   output logic                  req_bad,
   output logic [NVEC-1:0]       pend_bits,
   output logic                  msg_valid,
   input  logic                  msg_ready,
   output logic [ADDR_W-1:0]     msg_addr,
   output logic [PAYLOAD_W-1:0]  msg_data,
   output logic [RID_W-1:0]      msg_rid
);
   if (NVEC_LOG < 1 || NVEC_LOG > 5) begin : g_bad_nvec
      $error("NVEC_LOG must lie in 1..5");
   end
   if (ADDR_W < 32 || ADDR_W > 64) begin : g_bad_addr
      $error("ADDR_W must lie in 32..64");
   end
   if (RID_W < 1) begin : g_bad_rid
      $error("RID_W must be positive");
   end

   logic [LOG_FLD_W-1:0] eff_log;
   logic [NVEC-1:0]      in_range;
   logic [NVEC_LOG-1:0]  low_bits;
   logic                 vec_ok;

   msi_vec_lim #(.NVEC_LOG(NVEC_LOG)) i_lim (
      .cfg_log_vec (cfg_log_vec),
      .vec         (req_vec),
      .eff_log     (eff_log),
      .in_range    (in_range),
      .low_bits    (low_bits),
      .vec_ok      (vec_ok)
   );

   logic                msg_v_q;
   logic                drain_q;
   logic                slot_free;
   logic                req_take;
   logic                req_masked;
   logic                drain_go;
   logic                scan_send;
   logic                direct_send;
   logic                req_queue;
   logic                trim_en;
   logic [NVEC-1:0]     blocked;
   logic [NVEC-1:0]     set_bits;
   logic [NVEC-1:0]     clr_bits;
   logic                elig_any;
   logic [NVEC-1:0]     pick_bits;
   logic [NVEC_LOG-1:0] pick_idx;
   logic [NVEC_LOG-1:0] sel_vec;
   logic [ADDR_W-1:0]   nx_addr;
   logic [PAYLOAD_W-1:0] nx_data;

   assign slot_free   = !msg_v_q || msg_ready;
   assign blocked     = cfg_mask_cap ? cfg_mask : '0;
   assign req_take    = req_valid && vec_ok && cfg_enable;
   assign req_masked  = req_take && cfg_mask_cap && cfg_mask[req_vec];
   assign drain_go    = drain_q && cfg_enable && cfg_mask_cap;
   assign scan_send   = drain_go && elig_any && slot_free;
   assign direct_send = req_take && !req_masked && slot_free && !(drain_go && elig_any);
   assign req_queue   = req_take && !req_masked && !direct_send && cfg_mask_cap;
   assign trim_en     = cfg_wr_pulse && cfg_enable && cfg_mask_cap;
   assign set_bits    = (req_masked || req_queue) ? (NVEC'(1) << req_vec) : '0;
   assign clr_bits    = scan_send ? pick_bits : '0;
   assign sel_vec     = scan_send ? pick_idx : req_vec;

   msi_pend_arb #(.NVEC_LOG(NVEC_LOG)) i_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_en    (cfg_mask_cap),
      .trim_en   (trim_en),
      .in_range  (in_range),
      .blocked   (blocked),
      .set_bits  (set_bits),
      .clr_bits  (clr_bits),
      .pnd       (pend_bits),
      .elig_any  (elig_any),
      .pick_bits (pick_bits),
      .pick_idx  (pick_idx)
   );

   msi_msg_fmt #(.ADDR_W(ADDR_W), .NVEC_LOG(NVEC_LOG)) i_fmt (
      .cfg_addr   (cfg_addr),
      .cfg_addr64 (cfg_addr64),
      .cfg_data   (cfg_data),
      .low_bits   (low_bits),
      .vec        (sel_vec),
      .addr       (nx_addr),
      .data       (nx_data)
   );

   // drain request: raised by a config write or by a queued request
   always_ff @(posedge clk) begin
      if (!rst_n)                         drain_q <= 1'b0;
      else if (trim_en || req_queue)      drain_q <= 1'b1;
      else if (!cfg_enable || !cfg_mask_cap) drain_q <= 1'b0;
      else if (drain_q && !elig_any)      drain_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msg_v_q  <= 1'b0;
         msg_addr <= '0;
         msg_data <= '0;
         msg_rid  <= '0;
         req_bad  <= 1'b0;
      end else begin
         req_bad <= req_valid && !vec_ok;
         if (slot_free) begin
            msg_v_q <= scan_send || direct_send;
            if (scan_send || direct_send) begin
               msg_addr <= nx_addr;
               msg_data <= nx_data;
               msg_rid  <= func_rid;
            end
         end
      end
   end

   assign msg_valid = msg_v_q;
endmodule

// File: rtl/msi_vec_dispatch_chk.sv
module msi_vec_dispatch_chk
   import msi_disp_pkg::*;
#(
   parameter int NVEC_LOG = 5,
   parameter int ADDR_W   = 64,
   parameter int RID_W    = 16,
   localparam int NVEC = 1 << NVEC_LOG
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cfg_enable,
   input logic                  cfg_mask_cap,
   input logic [LOG_FLD_W-1:0]  cfg_log_vec,
   input logic [NVEC-1:0]       cfg_mask,
   input logic                  req_valid,
   input logic [NVEC_LOG-1:0]   req_vec,
   input logic                  req_bad,
   input logic [NVEC-1:0]       pend_bits,
   input logic                  msg_valid,
   input logic                  msg_ready,
   input logic [ADDR_W-1:0]     msg_addr,
   input logic [PAYLOAD_W-1:0]  msg_data
);
   int lim_log;
   logic legal;
   always_comb begin
      lim_log = (int'(cfg_log_vec) > NVEC_LOG) ? NVEC_LOG : int'(cfg_log_vec);
      legal   = int'(req_vec) < (1 << lim_log);
   end

   // R1
   bad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !legal |=> req_bad);
   // R1
   bad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !legal) |=> !req_bad);
   // R2
   off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable && !msg_valid |=> !msg_valid);
   // R2
   off_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable && cfg_mask_cap |=> $stable(pend_bits));
   // R4
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> msg_data[31:16] == 16'h0);
   // R5
   addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> msg_addr[1:0] == 2'b00);
   // R6
   mask_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && legal && cfg_enable && cfg_mask_cap && cfg_mask[req_vec]
      |=> pend_bits[$past(req_vec)]);
   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));
   // R10
   nocap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_mask_cap |=> pend_bits == '0);
endmodule

bind msi_vec_dispatch msi_vec_dispatch_chk #(
   .NVEC_LOG (NVEC_LOG),
   .ADDR_W   (ADDR_W),
   .RID_W    (RID_W)
) i_chk (.*);

// File: tb/test_msi_vec_dispatch.sv
module test_msi_vec_dispatch;
   localparam int NL = 5;
   localparam int NV = 32;
   localparam int AW = 64;
   localparam int RW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_enable = 1'b0;
   logic          cfg_mask_cap = 1'b0;
   logic          cfg_addr64 = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [15:0]   cfg_data = '0;
   logic [2:0]    cfg_log_vec = '0;
   logic [NV-1:0] cfg_mask = '0;
   logic          cfg_wr_pulse = 1'b0;
   logic [RW-1:0] func_rid = 16'h0A5C;
   logic          req_valid = 1'b0;
   logic [NL-1:0] req_vec = '0;
   logic          req_bad;
   logic [NV-1:0] pend_bits;
   logic          msg_valid;
   logic          msg_ready = 1'b1;
   logic [AW-1:0] msg_addr;
   logic [31:0]   msg_data;
   logic [RW-1:0] msg_rid;

   msi_vec_dispatch #(.NVEC_LOG(NL), .ADDR_W(AW), .RID_W(RW)) i_msi_vec_dispatch (
      .clk, .rst_n, .cfg_enable, .cfg_mask_cap, .cfg_addr64, .cfg_addr, .cfg_data,
      .cfg_log_vec, .cfg_mask, .cfg_wr_pulse, .func_rid, .req_valid, .req_vec,
      .req_bad, .pend_bits, .msg_valid, .msg_ready, .msg_addr, .msg_data, .msg_rid
   );

   always #10 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   logic [AW-1:0] q_addr[$];
   logic [31:0]   q_data[$];
   logic [RW-1:0] q_rid[$];

   always @(posedge clk) begin
      if (rst_n && msg_valid && msg_ready) begin
         q_addr.push_back(msg_addr);
         q_data.push_back(msg_data);
         q_rid.push_back(msg_rid);
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic fire(input int v);
      req_valid = 1'b1;
      req_vec   = NL'(v);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic cfg_write();
      cfg_wr_pulse = 1'b1;
      @(negedge clk);
      cfg_wr_pulse = 1'b0;
   endtask

   function automatic logic [31:0] exp_data(input int lg, input logic [15:0] d, input int v);
      int e;
      logic [15:0] m;
      e = (lg > NL) ? NL : lg;
      m = (16'd1 << e) - 16'd1;
      return {16'h0, (d & ~m) | (16'(v) & m)};
   endfunction

   function automatic logic [63:0] exp_addr(input logic [63:0] a, input logic w);
      return w ? {a[63:2], 2'b00} : {32'h0, a[31:2], 2'b00};
   endfunction

   task automatic expect_msg(input string tag, input logic [63:0] ea, input logic [31:0] ed);
      if (q_data.size() == 0) begin
         chk({tag, " message missing"}, 64'd0, 64'd1);
      end else begin
         chk({tag, " addr"}, q_addr.pop_front(), ea);
         chk({tag, " data"}, 64'(q_data.pop_front()), 64'(ed));
         chk({tag, " rid"}, 64'(q_rid.pop_front()), 64'(func_rid));
      end
   endtask

   task automatic expect_none(input string tag);
      chk({tag, " extra messages"}, 64'(q_data.size()), 64'd0);
      q_addr.delete(); q_data.delete(); q_rid.delete();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] sa;
      logic [31:0]   sd;
      void'($urandom(32'd4242));
      tick(3);
      rst_n = 1'b1;
      tick(1);
      chk("reset msg_valid R3", 64'(msg_valid), 0);
      chk("reset pend_bits R6", 64'(pend_bits), 0);
      chk("reset req_bad R1", 64'(req_bad), 0);

      // R4 R5: 64-bit address, 8 vectors
      cfg_enable = 1; cfg_addr64 = 1; cfg_addr = 64'h1234_5678_9ABC_DEF3;
      cfg_data = 16'hABC0; cfg_log_vec = 3;
      fire(5);
      chk("R3 valid after one edge", 64'(msg_valid), 1);
      tick(2);
      expect_msg("R4 R5 vec5 wide", 64'h1234_5678_9ABC_DEF0, 32'h0000_ABC5);
      expect_none("R4");

      // R5 narrow address
      cfg_addr64 = 0;
      fire(2); tick(2);
      expect_msg("R5 narrow", 64'h0000_0000_9ABC_DEF0, 32'h0000_ABC2);
      // R4 single vector: data untouched
      cfg_log_vec = 0; cfg_data = 16'h7FFF;
      fire(0); tick(2);
      expect_msg("R4 single vector", 64'h9ABC_DEF0, 32'h0000_7FFF);
      expect_none("R4 single");

      // R1 out of range and clamp
      cfg_log_vec = 2;
      fire(4);
      chk("R1 bad pulse", 64'(req_bad), 1);
      tick(1);
      chk("R1 bad pulse ends", 64'(req_bad), 0);
      tick(2);
      expect_none("R1 ignored");
      chk("R1 no pending", 64'(pend_bits), 0);
      cfg_log_vec = 7; cfg_data = 16'h0000;
      fire(31);
      chk("R1 clamp legal", 64'(req_bad), 0);
      tick(2);
      expect_msg("R1 clamp vec31", 64'h9ABC_DEF0, 32'h0000_001F);

      // R2 disabled
      cfg_enable = 0;
      fire(3); tick(3);
      expect_none("R2 disabled");
      chk("R2 no pending", 64'(pend_bits), 0);
      cfg_enable = 1;

      // R6 masked requests park
      cfg_mask_cap = 1; cfg_log_vec = 3; cfg_data = 16'h5500; cfg_mask = 32'h0A;
      fire(3); fire(1); tick(2);
      expect_none("R6 masked");
      chk("R6 pending", 64'(pend_bits), 64'h0A);

      // R8 partial unmask drain
      cfg_mask = 32'h02;
      cfg_write(); tick(4);
      expect_msg("R8 drain vec3", 64'h9ABC_DEF0, 32'h0000_5503);
      expect_none("R8 partial");
      chk("R8 masked stays", 64'(pend_bits), 64'h02);
      cfg_mask = 32'hFF;
      fire(6); fire(2); fire(5); tick(1);
      chk("R6 pending more", 64'(pend_bits), 64'h66);
      cfg_mask = 32'h00;
      cfg_write(); tick(7);
      expect_msg("R8 order 1", 64'h9ABC_DEF0, 32'h0000_5501);
      expect_msg("R8 order 2", 64'h9ABC_DEF0, 32'h0000_5502);
      expect_msg("R8 order 5", 64'h9ABC_DEF0, 32'h0000_5505);
      expect_msg("R8 order 6", 64'h9ABC_DEF0, 32'h0000_5506);
      expect_none("R8 order");
      chk("R8 cleared", 64'(pend_bits), 0);

      // R7 trim on shrink
      cfg_mask = 32'hFF;
      fire(7); fire(6); fire(1); tick(1);
      chk("R7 before trim", 64'(pend_bits), 64'hC2);
      cfg_log_vec = 1;
      cfg_write(); tick(2);
      chk("R7 trimmed", 64'(pend_bits), 64'h02);
      expect_none("R7 masked");
      cfg_mask = 0;
      cfg_write(); tick(4);
      expect_msg("R7 R8 after trim", 64'h9ABC_DEF0, 32'h0000_5501);
      expect_none("R7");

      // R9 stall and queue
      cfg_log_vec = 3; msg_ready = 0;
      fire(2);
      sa = msg_addr; sd = msg_data;
      fire(4); fire(1); tick(3);
      chk("R9 held valid", 64'(msg_valid), 1);
      chk("R9 held data", 64'(msg_data), 64'(sd));
      chk("R9 held addr", msg_addr, sa);
      chk("R9 queued", 64'(pend_bits), 64'h12);
      msg_ready = 1; tick(5);
      expect_msg("R9 first", 64'h9ABC_DEF0, 32'h0000_5502);
      expect_msg("R9 then 1", 64'h9ABC_DEF0, 32'h0000_5501);
      expect_msg("R9 then 4", 64'h9ABC_DEF0, 32'h0000_5504);
      expect_none("R9");

      // R10 no masking capability
      cfg_mask_cap = 0; cfg_mask = 32'hFF;
      fire(3); tick(2);
      expect_msg("R10 mask ignored", 64'h9ABC_DEF0, 32'h0000_5503);
      chk("R10 no pending", 64'(pend_bits), 0);
      msg_ready = 0;
      fire(2); fire(5); tick(2);
      chk("R10 busy drop pend", 64'(pend_bits), 0);
      msg_ready = 1; tick(4);
      expect_msg("R10 first kept", 64'h9ABC_DEF0, 32'h0000_5502);
      expect_none("R10 dropped");
      cfg_write(); tick(3);
      expect_none("R10 drain empty");

      // random sweep, masking off
      cfg_mask = '0;
      for (int it = 0; it < 200; it++) begin
         int lg;
         int v;
         int e;
         lg = int'($urandom_range(7, 0));
         v  = int'($urandom_range(31, 0));
         cfg_log_vec = 3'(lg);
         cfg_data    = 16'($urandom);
         cfg_addr    = {32'($urandom), 32'($urandom)};
         cfg_addr64  = 1'($urandom);
         e = (lg > NL) ? NL : lg;
         fire(v);
         chk("R1 random flag", 64'(req_bad), 64'(v >= (1 << e)));
         tick(2);
         if (v < (1 << e)) expect_msg("R4 R5 random", exp_addr(cfg_addr, cfg_addr64),
                                      exp_data(lg, cfg_data, v));
         expect_none("R1 random");
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule